// File: doc/BRIEF.md
# Coherence Home Directory Controller

This block is the home agent for a single memory line in a directory-based coherence scheme. It serves a parameterised number of cache nodes. It owns the line's memory copy and a bit set of the nodes that hold a valid copy. It also keeps a bit set of nodes still owed an invalidation, a flag recording that an exclusive copy is out, and the one request currently being served.

Each node has three channels to the home. The first is a request channel that the cache drives and the home empties. The second is an acknowledgement channel that the cache drives with a data word and the home empties. The third is a grant channel that the home holds as a register, and the cache empties it with a take pulse.

The home takes on one request at a time, choosing round-robin among the nodes that are asking. It sends invalidations where the request calls for them and absorbs the acknowledgements. When the exclusive holder acknowledges, its data is written back to memory. Once the conditions are clear, the home grants a shared or exclusive copy carrying the memory data.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every grant channel is empty (code 0), no request or acknowledgement is popped, memory holds 0, and with no sharers a lone exclusive request has its grant visible two clock edges after the request is first presented.
- R2: A request (2-bit field `req_cmd[2i+1:2i]`, 1 = shared, 2 = exclusive, 0 or 3 = none) is popped only when no request is being served. At most one request is popped per cycle. A request presented while another is in service stays unpopped.
- R3: When several nodes request at once, the accepted node is the first requester found by counting upward, with wrap-around, from the node accepted last.
- R4: An exclusive grant (grant code 3) is issued only once no node holds a copy and no exclusive copy is out. It carries the current memory data, and it makes the requester the only holder.
- R5: A shared grant (grant code 2) is issued when no exclusive copy is out, and it carries the current memory data. Existing sharers are not invalidated for a shared request.
- R6: Accepting a request snapshots the holder set as the set of nodes to invalidate. An invalidation (grant code 1) goes to each of these nodes for an exclusive request, and for a shared request only while an exclusive copy is out.
- R7: An acknowledgement from a node while a request is pending and an exclusive copy is out writes that node's data word into memory, clears the exclusive flag and removes the node from the holder set.
- R8: An acknowledgement while no exclusive copy is out only removes the node from the holder set. Its data word does not change memory.
- R9: A grant-channel entry (field `gnt_cmd[2i+1:2i]`, data `gnt_data[DW*i +: DW]`) is held unchanged until the node pulses `gnt_take[i]`. No new message is written while the entry is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | 2*NODES | Per-node request field |
| req_pop | output | NODES | Per-node request consumed this cycle |
| ack_vld | input | NODES | Per-node acknowledgement present |
| ack_data | input | NODES*DW | Per-node acknowledgement data |
| ack_pop | output | NODES | Per-node acknowledgement consumed this cycle |
| gnt_take | input | NODES | Per-node pulse that empties the grant channel |
| gnt_cmd | output | 2*NODES | Per-node grant channel code |
| gnt_data | output | NODES*DW | Per-node grant channel data |

## Verification
The bench models four caches that store a fresh value each time they gain exclusive ownership. Every grant's data must therefore match the latest stored value. A home that skipped the write-back, or that let a sharer's acknowledgement overwrite memory, would hand out stale or corrupted data. The caches acknowledge shared copies with inverted data to expose the second of these faults.

Simultaneous requests check the wrap-around order of the rotating pick; a fixed-priority pick would grant in the wrong order. A grant channel is held full deliberately, to show that a waiting invalidation is not overwritten and that a second request is not accepted while the first is blocked. A sweep of every node and request kind, including a sharer upgrading to exclusive, catches a home that grants exclusivity while copies remain.

// File: rtl/coh_home_dir.sv
module coh_home_dir #(
  parameter int NODES = 4,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NODES-1:0]  req_cmd,
  output logic [NODES-1:0]    req_pop,
  input  logic [NODES-1:0]    ack_vld,
  input  logic [NODES*DW-1:0] ack_data,
  output logic [NODES-1:0]    ack_pop,
  input  logic [NODES-1:0]    gnt_take,
  output logic [2*NODES-1:0]  gnt_cmd,
  output logic [NODES*DW-1:0] gnt_data
);
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1;
  localparam logic [1:0] C_NONE = 2'd0, C_SH = 2'd1, C_EX = 2'd2;
  localparam logic [1:0] G_INV = 2'd1, G_S = 2'd2, G_E = 2'd3;

  logic [1:0]       cur;
  logic [IW-1:0]    ptr, rr, pick, ack_i;
  logic [NODES-1:0] shr, inv, shr_ack, snd_inv, req_any;
  logic             exg, pick_ok, ack_ok, accept, ack_e;
  logic             gnt_e_ok, gnt_s_ok, grant;
  logic [DW-1:0]    mem;
  logic [1:0]       gcmd [NODES];
  logic [DW-1:0]    gdat [NODES];

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int k = 1; k <= NODES; k++) begin
      int j;
      j = (int'(rr) + k) % NODES;
      if (!pick_ok && req_any[j]) begin
        pick_ok = 1'b1;
        pick    = IW'(j);
      end
    end
  end

  always_comb begin
    ack_ok = 1'b0;
    ack_i  = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (ack_vld[i] && (!exg || cur != C_NONE)) begin
        ack_ok = 1'b1;
        ack_i  = IW'(i);
      end
  end

  always_comb begin
    shr_ack = shr;
    if (ack_ok) shr_ack[ack_i] = 1'b0;
  end

  assign accept   = (cur == C_NONE) && pick_ok;
  assign ack_e    = ack_ok && exg;
  assign gnt_e_ok = (cur == C_EX) && (shr == '0) && !exg && (gcmd[ptr] == 2'd0);
  assign gnt_s_ok = (cur == C_SH) && !exg && (gcmd[ptr] == 2'd0);
  assign grant    = gnt_e_ok || gnt_s_ok;

  genvar g;
  generate
    for (g = 0; g < NODES; g++) begin : g_node
      assign req_any[g] = (req_cmd[2*g +: 2] == C_SH) || (req_cmd[2*g +: 2] == C_EX);
      assign req_pop[g] = accept && (pick == IW'(g));
      assign ack_pop[g] = ack_ok && (ack_i == IW'(g));
      assign snd_inv[g] = inv[g] && (gcmd[g] == 2'd0) &&
                          ((cur == C_EX) || ((cur == C_SH) && exg));
      assign gnt_cmd[2*g +: 2]   = gcmd[g];
      assign gnt_data[DW*g +: DW] = gdat[g];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          gcmd[g] <= 2'd0;
          gdat[g] <= '0;
        end else if (gcmd[g] != 2'd0) begin
          if (gnt_take[g]) gcmd[g] <= 2'd0;
        end else if (snd_inv[g]) begin
          gcmd[g] <= G_INV;
        end else if (grant && (ptr == IW'(g))) begin
          gcmd[g] <= gnt_e_ok ? G_E : G_S;
          gdat[g] <= mem;
        end
      end

      assert_ch2_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gcmd[g] != 2'd0 && !gnt_take[g]) |=> ($stable(gcmd[g]) && $stable(gdat[g])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= C_NONE;
      ptr <= '0;
      rr  <= IW'(NODES - 1);
      shr <= '0;
      inv <= '0;
      exg <= 1'b0;
      mem <= '0;
    end else begin
      shr <= shr_ack;
      if (grant) shr[ptr] <= 1'b1;
      if (accept) begin
        cur <= req_cmd[2*pick +: 2];
        ptr <= pick;
        rr  <= pick;
        inv <= shr_ack;
      end else begin
        inv <= inv & ~snd_inv;
        if (grant) cur <= C_NONE;
      end
      if (ack_e) begin
        exg <= 1'b0;
        mem <= ack_data[DW*ack_i +: DW];
      end else if (gnt_e_ok) begin
        exg <= 1'b1;
      end
    end
  end

  assert_pop_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_pop));
  assert_busy_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop != '0) |=> (cur != C_NONE && req_pop == '0));
  assert_single_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exg |-> ($countones(shr) <= 1));
  assert_excl_from_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exg) |-> ($past(shr) == '0));
  assert_wb_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exg) |-> $past(ack_pop != '0));
endmodule

// File: tb/test_coh_home_dir.sv
module test_coh_home_dir;
  localparam int N = 4, DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2*N-1:0]  req_cmd = '0;
  logic [N-1:0]    req_pop, ack_pop;
  logic [N-1:0]    ack_vld = '0, gnt_take = '0;
  logic [N*DW-1:0] ack_data = '0;
  logic [2*N-1:0]  gnt_cmd;
  logic [N*DW-1:0] gnt_data;

  coh_home_dir #(.NODES(N), .DW(DW)) i_coh_home_dir (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_pop(req_pop),
    .ack_vld(ack_vld), .ack_data(ack_data), .ack_pop(ack_pop),
    .gnt_take(gnt_take), .gnt_cmd(gnt_cmd), .gnt_data(gnt_data));

  int checks = 0, fails = 0, cyc = 0, gn = 0;
  int cst[N], ninv[N], gcyc[N], gseq[256];
  logic [DW-1:0] cdat[N];
  logic [DW-1:0] aux = '0;
  bit hold[N], popr[N], popa[N];
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    int ne, nv;
    #1;
    for (int i = 0; i < N; i++) begin
      popr[i] = req_pop[i];
      popa[i] = ack_pop[i];
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (popr[i]) req_cmd[2*i +: 2] = 2'd0;
      if (popa[i]) ack_vld[i] = 1'b0;
      gnt_take[i] = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      logic [1:0] c;
      logic [DW-1:0] d;
      c = gnt_cmd[2*i +: 2];
      d = gnt_data[DW*i +: DW];
      if (c != 2'd0 && !hold[i]) begin
        gnt_take[i] = 1'b1;
        gcyc[i] = cyc;
        if (c == 2'd1) begin
          ninv[i]++;
          ack_vld[i] = 1'b1;
          ack_data[DW*i +: DW] = (cst[i] == 2) ? cdat[i] : ~cdat[i];
          cst[i] = 0;
        end else if (c == 2'd2) begin
          chk(d == aux, "R5", "shared grant data", int'(d), int'(aux));
          cst[i] = 1; cdat[i] = d; gseq[gn] = i; gn++;
        end else begin
          chk(d == aux, "R4", "exclusive grant data", int'(d), int'(aux));
          cst[i] = 2; cdat[i] = d + DW'(i + 1); aux = cdat[i];
          gseq[gn] = i; gn++;
        end
      end
    end
    ne = 0; nv = 0;
    for (int i = 0; i < N; i++) begin
      if (cst[i] == 2) ne++;
      if (cst[i] != 0) nv++;
    end
    if (ne > 0) chk(nv == 1, "R4", "copies beside exclusive", nv, 1);
  endtask

  task automatic settle();
    int q = 0;
    for (int k = 0; k < 400; k++) begin
      tick();
      if (req_cmd == '0 && ack_vld == '0 && gnt_cmd == '0) q++; else q = 0;
      if (q >= 3) break;
    end
  endtask

  task automatic clr_inv();
    for (int i = 0; i < N; i++) ninv[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      cst[i] = 0; ninv[i] = 0; gcyc[i] = 0; cdat[i] = '0; hold[i] = 0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk(gnt_cmd == '0, "R1", "grant channels after reset", int'(gnt_cmd), 0);
    chk(req_pop == '0 && ack_pop == '0, "R1", "pops after reset", int'({req_pop, ack_pop}), 0);

    begin
      int c0;
      c0 = cyc;
      req_cmd[5:4] = 2'd2;
      #1;
      chk(req_pop == 4'b0100, "R2", "pop of lone request", int'(req_pop), 4);
      settle();
      chk(gcyc[2] == c0 + 2, "R1", "exclusive grant latency", gcyc[2] - c0, 2);
      chk(cst[2] == 2, "R4", "node2 exclusive", cst[2], 2);
    end

    clr_inv();
    req_cmd[1:0] = 2'd1;
    settle();
    chk(ninv[2] == 1, "R6", "holder invalidated for shared", ninv[2], 1);
    chk(cst[0] == 1 && cdat[0] == 8'h03, "R7", "written-back data reached sharer", int'(cdat[0]), 3);

    clr_inv();
    gn = 0;
    req_cmd[3:2] = 2'd1; req_cmd[7:6] = 2'd1;
    settle();
    chk(gseq[0] == 1 && gseq[1] == 3, "R3", "order of 1,3", gseq[0]*10 + gseq[1], 13);
    chk(ninv[0] == 0, "R5", "sharer untouched by shared", ninv[0], 0);

    clr_inv();
    req_cmd[5:4] = 2'd2;
    settle();
    chk(ninv[0] == 1 && ninv[1] == 1 && ninv[3] == 1, "R6", "all sharers invalidated",
        ninv[0] + ninv[1] + ninv[3], 3);
    chk(ninv[2] == 0, "R6", "requester not invalidated", ninv[2], 0);
    chk(cst[2] == 2, "R8", "exclusive after sharer acks", cst[2], 2);

    gn = 0;
    req_cmd[1:0] = 2'd2; req_cmd[3:2] = 2'd2; req_cmd[7:6] = 2'd2;
    settle();
    chk(gn == 3 && gseq[0] == 3 && gseq[1] == 0 && gseq[2] == 1, "R3", "wrapped order 3,0,1",
        gseq[0]*100 + gseq[1]*10 + gseq[2], 301);
    chk(cst[1] == 2, "R7", "last exclusive holder", cst[1], 2);

    hold[1] = 1;
    req_cmd[7:6] = 2'd2;
    repeat (3) tick();
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(gnt_cmd[3:2] == 2'd1, "R9", "held invalidation", int'(gnt_cmd[3:2]), 1);
    end
    req_cmd[1:0] = 2'd1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req_pop == '0, "R2", "pop while busy", int'(req_pop), 0);
      tick();
      chk(req_cmd[1:0] == 2'd1, "R2", "request still pending", int'(req_cmd[1:0]), 1);
    end
    hold[1] = 0;
    settle();
    chk(cst[3] == 0 && cst[0] == 1 && cst[1] == 0, "R9", "flow after release",
        cst[0]*100 + cst[1]*10 + cst[3], 100);

    for (int i = 0; i < N; i++)
      for (int k = 1; k <= 2; k++) begin
        req_cmd[2*i +: 2] = 2'(k);
        settle();
        chk(cst[i] == k, k == 1 ? "R5" : "R4", "sweep state", cst[i], k);
      end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule